// File: doc/BRIEF.md
# Cache Maintenance Engine

This block runs maintenance commands against a small direct-mapped write-back data cache that it holds in an internal register array. Two commands are supported. A line flush takes a byte address. If the line holding that address is present it is invalidated, and a modified line is first written back over a valid/ready memory port. If the line is not present, nothing happens. A cache invalidate drops every line, dirty or clean, with no write-back at all. It also signals any external cache to invalidate itself, through a one-cycle special-cycle strobe that carries a flush code on a 4-bit byte-enable field.

Each command carries a privilege level. A line flush is legal at any level. The invalidate is legal only at level 0. At any other level the invalidate is rejected with a one-cycle fault pulse and leaves the cache untouched. A fill port stands in for the surrounding cache model and installs lines. A combinational probe port reports the stored state of any address. While a command is in progress the block holds busy high and ignores both new commands and fills.

Top module: `cache_maint_engine`

## Requirements
- R1: A line flush whose line is absent (the valid bit is clear, or the stored tag differs) issues no write-back and changes no line. Busy is high for exactly one cycle, then done pulses.
- R2: A line flush that hits a clean line clears that line's valid bit and issues no write-back.
- R3: A line flush that hits a modified line issues exactly one write-back. Its address is the line base (offset bits zero) and its data is the stored line. After that the line is invalid.
- R4: While a write-back is offered and not accepted, memWrValid stays high, memWrAddr stays unchanged and the line stays valid. The line is invalidated only in the cycle the write-back is accepted.
- R5: A line flush behaves the same at every privilege level and never raises fault.
- R6: An invalidate at privilege 0 (cmdOp=1) clears every line, dirty ones included, with no write-back. Busy is high for exactly NUM_LINES cycles, then done pulses.
- R7: An accepted invalidate at privilege 0 produces exactly one specCycle pulse, during busy, with specBe equal to 4'b0001.
- R8: An invalidate at nonzero privilege produces a fault pulse one cycle long in the cycle after acceptance. It produces no busy, no specCycle and no write-back, and it changes no line.
- R9: A command presented while busy is high is ignored: it causes no write-back, no fault and no state change.
- R10: After reset every line is invalid and busy, done, fault, memWrValid and specCycle are all low.
- R11: A fill while busy is low installs the line at fillAddr with its data and dirty flag, replacing whatever that index held. The probe port reports the installed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present; accepted when busy is low |
| cmdOp | input | 1 | 0 = line flush, 1 = invalidate all lines |
| cmdAddr | input | ADDR_W | Byte address for a line flush |
| cmdPriv | input | PRIV_W | Privilege level of the command, 0 most privileged |
| fillValid | input | 1 | Install a line (ignored while busy) |
| fillAddr | input | ADDR_W | Byte address of the line to install |
| fillData | input | LINE_W | Line data to install |
| fillDirty | input | 1 | Install the line as modified |
| probeAddr | input | ADDR_W | Address to inspect |
| probeHit | output | 1 | Probed address is present |
| probeDirty | output | 1 | Probed line is modified (valid only with probeHit) |
| probeData | output | LINE_W | Stored data at the probed index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after a command completes |
| fault | output | 1 | One-cycle pulse for an illegal invalidate |
| memWrValid | output | 1 | Write-back offered |
| memWrReady | input | 1 | Memory accepts the write-back |
| memWrAddr | output | ADDR_W | Write-back line base address |
| memWrData | output | LINE_W | Write-back line data |
| specCycle | output | 1 | Special bus cycle strobe |
| specBe | output | 4 | Byte-enable message code during specCycle |

## Verification
The hardest situation to reach from the ports is a command arriving while the engine is in the middle of its work. Two cases matter: a write-back held off by memory, and an invalidate sweep that has cleared only part of the array. The stimulus reaches both in two ways. It stalls memWrReady on random cycles, and it injects a second command in the first busy cycle. It targets a dirty line that a correct design must leave alone, or lose silently through the sweep. A random mix of fills, flushes and invalidates at all privilege levels draws tags from a set of two, so hits, clean and dirty conflicts, and misses on a valid line all occur often.

// File: rtl/cache_maint_pkg.sv
package cache_maint_pkg;

  localparam logic [3:0] SPEC_FLUSH_CODE = 4'b0001;

  typedef enum logic {
    OP_FLUSH_LINE = 1'b0,
    OP_INV_ALL    = 1'b1
  } maint_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRBACK,
    ST_SWEEP
  } maint_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allowFill;
    logic latchCmd;
    logic clrHit;
    logic clrSweep;
    logic sweepStart;
  } maint_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic dirty;
    logic sweepLast;
  } maint_status_t;

endpackage

// File: rtl/cache_maint_datapath.sv
module cache_maint_datapath
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  maint_ctrl_t       ctrl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LINE_W-1:0] fillData,
  input  logic              fillDirty,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic              probeDirty,
  output logic [LINE_W-1:0] probeData,
  output maint_status_t     status,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [LINE_W-1:0] memWrData
);

  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LADR_W = ADDR_W - OFF_W;

  logic [NUM_LINES-1:0] lineValid;
  logic [NUM_LINES-1:0] lineDirty;
  logic [TAG_W-1:0]     lineTag  [NUM_LINES];
  logic [LINE_W-1:0]    lineData [NUM_LINES];

  logic [LADR_W-1:0] cmdLineQ;
  logic [IDX_W-1:0]  sweepIdx;

  logic [IDX_W-1:0] curIdx, fillIdx, probeIdx;
  logic [TAG_W-1:0] curTag, fillTag, probeTag;
  logic             fillWe;

  assign curIdx   = cmdLineQ[IDX_W-1:0];
  assign curTag   = cmdLineQ[LADR_W-1:IDX_W];
  assign fillIdx  = fillAddr[OFF_W +: IDX_W];
  assign fillTag  = fillAddr[ADDR_W-1 -: TAG_W];
  assign probeIdx = probeAddr[OFF_W +: IDX_W];
  assign probeTag = probeAddr[ADDR_W-1 -: TAG_W];
  assign fillWe   = fillValid && ctrl.allowFill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLineQ <= '0;
    end else if (ctrl.latchCmd) begin
      cmdLineQ <= cmdAddr[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepIdx <= '0;
    end else if (ctrl.sweepStart) begin
      sweepIdx <= '0;
    end else if (ctrl.clrSweep) begin
      sweepIdx <= sweepIdx + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic clrThis;
    assign clrThis = (ctrl.clrHit && curIdx == IDX_W'(i)) ||
                     (ctrl.clrSweep && sweepIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineValid[i] <= 1'b0;
        lineDirty[i] <= 1'b0;
        lineTag[i]   <= '0;
        lineData[i]  <= '0;
      end else if (fillWe && fillIdx == IDX_W'(i)) begin
        lineValid[i] <= 1'b1;
        lineDirty[i] <= fillDirty;
        lineTag[i]   <= fillTag;
        lineData[i]  <= fillData;
      end else if (clrThis) begin
        lineValid[i] <= 1'b0;
        lineDirty[i] <= 1'b0;
      end
    end
  end

  assign status.hit       = lineValid[curIdx] && (lineTag[curIdx] == curTag);
  assign status.dirty     = lineDirty[curIdx];
  assign status.sweepLast = (sweepIdx == IDX_W'(NUM_LINES - 1));

  assign memWrAddr = {curTag, curIdx, {OFF_W{1'b0}}};
  assign memWrData = lineData[curIdx];

  assign probeHit   = lineValid[probeIdx] && (lineTag[probeIdx] == probeTag);
  assign probeDirty = lineDirty[probeIdx];
  assign probeData  = lineData[probeIdx];

  // R2: control only clears a looked-up line that the tag match reports present
  p_clear_needs_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrHit |-> status.hit);

  // R6: the sweep slot just visited is invalid afterwards
  p_sweep_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrSweep |=> !lineValid[$past(sweepIdx)]);

  // R9: the latched command does not move while a command is running
  p_latch_only_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.allowFill |-> !ctrl.latchCmd);

endmodule

// File: rtl/cache_maint_control.sv
module cache_maint_control
  import cache_maint_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic [PRIV_W-1:0] cmdPriv,
  input  maint_status_t     status,
  input  logic              memWrReady,
  output maint_ctrl_t       ctrl,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              memWrValid,
  output logic              specCycle
);

  maint_state_e state, stateNext;
  logic doneNext, faultNext, specNext;
  logic accept, invLegal;

  assign accept   = cmdValid && (state == ST_IDLE);
  assign invLegal = (cmdPriv == '0);

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    doneNext  = 1'b0;
    faultNext = 1'b0;
    specNext  = 1'b0;
    ctrl.allowFill = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (maint_op_e'(cmdOp) == OP_INV_ALL) begin
            if (invLegal) begin
              stateNext       = ST_SWEEP;
              ctrl.sweepStart = 1'b1;
              specNext        = 1'b1;
            end else begin
              faultNext = 1'b1;
            end
          end else begin
            ctrl.latchCmd = 1'b1;
            stateNext     = ST_LOOKUP;
          end
        end
      end
      ST_LOOKUP: begin
        if (status.hit && status.dirty) begin
          stateNext = ST_WRBACK;
        end else begin
          ctrl.clrHit = status.hit;
          stateNext   = ST_IDLE;
          doneNext    = 1'b1;
        end
      end
      ST_WRBACK: begin
        if (memWrReady) begin
          ctrl.clrHit = 1'b1;
          stateNext   = ST_IDLE;
          doneNext    = 1'b1;
        end
      end
      ST_SWEEP: begin
        ctrl.clrSweep = 1'b1;
        if (status.sweepLast) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      fault     <= 1'b0;
      specCycle <= 1'b0;
    end else begin
      state     <= stateNext;
      done      <= doneNext;
      fault     <= faultNext;
      specCycle <= specNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign memWrValid = (state == ST_WRBACK);

  // R4: an offered write-back is held until accepted
  p_wb_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && !memWrReady |=> memWrValid);

  // R6: no write-back is ever offered while sweeping
  p_sweep_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrSweep |-> !memWrValid);

  // R7: the special-cycle strobe is a single pulse inside the busy window
  p_spec_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    specCycle |-> busy ##1 !specCycle);

  // R8: fault is a lone pulse and never overlaps work
  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !busy ##1 !fault);

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cache_maint_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 64,
  parameter int PRIV_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [PRIV_W-1:0] cmdPriv,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [LINE_W-1:0] fillData,
  input  logic              fillDirty,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic              probeDirty,
  output logic [LINE_W-1:0] probeData,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [LINE_W-1:0] memWrData,
  output logic              specCycle,
  output logic [3:0]        specBe
);

  maint_ctrl_t   ctrl;
  maint_status_t status;

  cache_maint_control #(.PRIV_W(PRIV_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdPriv    (cmdPriv),
    .status     (status),
    .memWrReady (memWrReady),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .memWrValid (memWrValid),
    .specCycle  (specCycle)
  );

  cache_maint_datapath #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cmdAddr    (cmdAddr),
    .fillValid  (fillValid),
    .fillAddr   (fillAddr),
    .fillData   (fillData),
    .fillDirty  (fillDirty),
    .probeAddr  (probeAddr),
    .probeHit   (probeHit),
    .probeDirty (probeDirty),
    .probeData  (probeData),
    .status     (status),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

  assign specBe = specCycle ? SPEC_FLUSH_CODE : 4'b0000;

  // R4: address and data of a stalled write-back do not change
  p_wb_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && !memWrReady |=> $stable(memWrAddr) && $stable(memWrData));

endmodule

// File: tb/cache_maint_engine_tb.sv
`timescale 1ns/1ps
module cache_maint_engine_tb_top;

  localparam int ADDR_W = 16;
  localparam int OFF_W  = 4;
  localparam int NLINES = 8;
  localparam int LINE_W = 64;
  localparam int PRIV_W = 2;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdOp = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [PRIV_W-1:0] cmdPriv = '0;
  logic fillValid = 1'b0, fillDirty = 1'b0;
  logic [ADDR_W-1:0] fillAddr = '0, probeAddr = '0;
  logic [LINE_W-1:0] fillData = '0;
  logic probeHit, probeDirty, busy, done, fault, memWrValid, specCycle;
  logic memWrReady = 1'b0;
  logic [LINE_W-1:0] probeData, memWrData;
  logic [ADDR_W-1:0] memWrAddr;
  logic [3:0] specBe;

  always #2 clk = ~clk;

  cache_maint_engine dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdPriv(cmdPriv), .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillDirty(fillDirty), .probeAddr(probeAddr), .probeHit(probeHit),
    .probeDirty(probeDirty), .probeData(probeData), .busy(busy), .done(done),
    .fault(fault), .memWrValid(memWrValid), .memWrReady(memWrReady),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .specCycle(specCycle), .specBe(specBe)
  );

  int errors = 0, checks = 0;
  int busyCnt = 0, specCnt = 0, faultCnt = 0, wbCnt = 0;
  logic [ADDR_W-1:0] wbAddr, pendAddr;
  logic [LINE_W-1:0] wbData;
  logic pendQ = 1'b0;
  bit stallOn = 0;
  bit monOn = 0;

  // reference model
  bit               mV [NLINES];
  bit               mD [NLINES];
  logic [TAG_W-1:0] mT [NLINES];
  logic [LINE_W-1:0] mData [NLINES];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [TAG_W-1:0] t, input int idx, input int off);
    return {t, IDX_W'(idx), OFF_W'(off)};
  endfunction

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      memWrReady = stallOn ? ($urandom % 4 == 0) : 1'b1;
    end
  end

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (monOn) begin
      if (busy) busyCnt++;
      if (specCycle) begin
        specCnt++;
        chk(specBe == 4'b0001, "R7 specBe", 64'(specBe), 64'h1);
      end
      if (fault) faultCnt++;
      if (memWrValid && memWrReady) begin
        wbCnt++; wbAddr = memWrAddr; wbData = memWrData;
      end
      if (pendQ) chk(memWrValid && memWrAddr == pendAddr && probeHit, "R4 held write-back",
                     64'({memWrValid, probeHit}), 64'h3);
      pendQ    = memWrValid && !memWrReady;
      pendAddr = memWrAddr;
    end
  end

  task automatic doFill(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d, input bit dirty);
    int idx;
    @(posedge clk); #1;
    fillValid = 1'b1; fillAddr = a; fillData = d; fillDirty = dirty;
    @(posedge clk); #1;
    fillValid = 1'b0;
    idx = int'(a[OFF_W +: IDX_W]);
    mV[idx] = 1; mD[idx] = dirty; mT[idx] = a[ADDR_W-1 -: TAG_W]; mData[idx] = d;
  endtask

  task automatic verifyAll(input string req);
    bit ok = 1;
    for (int i = 0; i < NLINES; i++) begin
      @(posedge clk); #1;
      probeAddr = mkAddr(mT[i], i, 0);
      @(negedge clk);
      if (probeHit !== mV[i]) ok = 0;
      if (mV[i] && (probeDirty !== mD[i] || probeData !== mData[i])) ok = 0;
    end
    chk(ok, req, 64'(probeHit), 64'(1));
  endtask

  task automatic runCmd(input bit op, input logic [ADDR_W-1:0] a, input logic [PRIV_W-1:0] pv,
                        input bit inj, input bit injOp, input logic [ADDR_W-1:0] injAddr,
                        input string req);
    int idx, b0, s0, f0, w0, n;
    bit hit, expWb;
    logic [ADDR_W-1:0] expAddr;
    logic [LINE_W-1:0] expData;
    idx = int'(a[OFF_W +: IDX_W]);
    hit = mV[idx] && mT[idx] == a[ADDR_W-1 -: TAG_W];
    expWb = (op == 1'b0) && hit && mD[idx];
    expAddr = {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    expData = mData[idx];
    b0 = busyCnt; s0 = specCnt; f0 = faultCnt; w0 = wbCnt;
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdPriv = pv; probeAddr = a;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    if (inj) begin
      cmdValid = 1'b1; cmdOp = injOp; cmdAddr = injAddr; cmdPriv = '0;
      @(posedge clk); #1;
      cmdValid = 1'b0;
    end
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (done || fault || n > 200) break;
    end
    @(negedge clk);
    if (op == 1'b0) begin
      chk(wbCnt - w0 == int'(expWb), {req, " wb count"}, 64'(wbCnt - w0), 64'(expWb));
      if (expWb) begin
        chk(wbAddr == expAddr, {req, " wb addr"}, 64'(wbAddr), 64'(expAddr));
        chk(wbData == expData, {req, " wb data"}, wbData, expData);
      end else begin
        chk(busyCnt - b0 == 1, {req, " busy cycles"}, 64'(busyCnt - b0), 64'd1);
      end
      chk(faultCnt == f0 && specCnt == s0, {req, " R5 no fault"}, 64'(faultCnt - f0), 64'd0);
      if (hit) begin mV[idx] = 0; mD[idx] = 0; end
    end else if (pv == '0) begin
      chk(busyCnt - b0 == NLINES, {req, " R6 busy cycles"}, 64'(busyCnt - b0), 64'(NLINES));
      chk(specCnt - s0 == 1, {req, " R7 spec pulses"}, 64'(specCnt - s0), 64'd1);
      chk(wbCnt == w0, {req, " R6 no wb"}, 64'(wbCnt - w0), 64'd0);
      for (int i = 0; i < NLINES; i++) begin mV[i] = 0; mD[i] = 0; end
    end else begin
      chk(faultCnt - f0 == 1 && busyCnt == b0 && specCnt == s0 && wbCnt == w0,
          {req, " R8 fault only"}, 64'(faultCnt - f0), 64'd1);
    end
    verifyAll({req, " state"});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NLINES; i++) begin mV[i] = 0; mD[i] = 0; mT[i] = '0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !memWrValid && !specCycle, "R10 reset outputs",
        64'({busy, done, fault, memWrValid, specCycle}), 64'd0);
    verifyAll("R10 reset lines invalid");
    monOn = 1;

    // R11 fills
    doFill(mkAddr(9'd3, 2, 7), 64'hDEAD_BEEF_0000_0002, 1);
    doFill(mkAddr(9'd5, 5, 0), 64'h1234_5678_9ABC_0005, 0);
    verifyAll("R11 fill visible");
    doFill(mkAddr(9'd5, 5, 3), 64'h5555_0000_0000_0005, 1);
    verifyAll("R11 fill replaces");

    // R1 miss on valid index with other tag
    runCmd(1'b0, mkAddr(9'd5, 2, 9), 2'd0, 0, 0, '0, "R1 miss");
    // R1 miss on invalid index
    runCmd(1'b0, mkAddr(9'd3, 6, 0), 2'd1, 0, 0, '0, "R1 miss empty");
    // R2 clean hit at privilege 3 (R5)
    doFill(mkAddr(9'd3, 4, 0), 64'hC1EA_0000_0000_0004, 0);
    runCmd(1'b0, mkAddr(9'd3, 4, 15), 2'd3, 0, 0, '0, "R2 clean hit");
    // R3/R4 dirty hit with stalls
    stallOn = 1;
    runCmd(1'b0, mkAddr(9'd3, 2, 1), 2'd2, 0, 0, '0, "R3 dirty hit");
    // R9: illegal-free invalidate injected during stalled write-back
    doFill(mkAddr(9'd5, 1, 0), 64'hAAAA_0000_0000_0001, 1);
    doFill(mkAddr(9'd3, 4, 0), 64'hBBBB_0000_0000_0004, 1);
    runCmd(1'b0, mkAddr(9'd5, 1, 0), 2'd1, 1, 1'b1, '0, "R9 inject inv during flush");
    stallOn = 0;
    // R8 illegal invalidate
    runCmd(1'b1, '0, 2'd1, 0, 0, '0, "R8 priv1");
    runCmd(1'b1, '0, 2'd3, 0, 0, '0, "R8 priv3");
    // R6/R7 with an injected flush of a dirty line (R9)
    runCmd(1'b1, '0, 2'd0, 1, 1'b0, mkAddr(9'd3, 4, 0), "R6 R9 inv with inject");

    // random mix
    for (int k = 0; k < 250; k++) begin
      int r, idx;
      logic [TAG_W-1:0] t;
      r = int'($urandom % 100);
      idx = int'($urandom % NLINES);
      t = ($urandom % 2) ? 9'd3 : 9'd5;
      stallOn = ($urandom % 2) == 1;
      if (r < 50)
        doFill(mkAddr(t, idx, int'($urandom % 16)), {$urandom, $urandom}, ($urandom % 2) == 1);
      else if (r < 85)
        runCmd(1'b0, mkAddr(t, idx, int'($urandom % 16)), PRIV_W'($urandom), 0, 0, '0, "R3 random flush");
      else
        runCmd(1'b1, '0, PRIV_W'($urandom), 0, 0, '0, "R6 random invalidate");
    end
    verifyAll("R11 final state");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule